// File: doc/BRIEF.md
# Two-Length Delta Pixel Encoder

This block compresses a stream of 12-bit raw image samples before they are written to storage. Each sample arrives with a channel index. The block subtracts the last reconstructed value of that same channel from the sample and sends the difference as a variable-length code. A code starts with one prefix bit. A prefix of 0 means a 6-bit code that carries a 5-bit difference. A prefix of 1 means a 12-bit code that carries an 11-bit difference. A difference too large for the long code is clamped, and the part that was not sent is carried into the channel's next samples.

Codes are packed MSB-first into 16-bit words and leave on a valid/ready stream. A flush request closes the final partial word: the word is padded with zeros and sent together with its count of meaningful bits. A frame-start pulse clears every channel predictor, so each frame can be decoded on its own.

Top module: `delta_pack_enc`

## Requirements
- R1: When the difference between the sample and the channel predictor lies in -16..+15, the block emits 6 bits: a 0, then the difference as 5-bit two's complement.
- R2: When the difference lies outside -16..+15 but inside -1024..+1023, the block emits 12 bits: a 1, then the difference as 11-bit two's complement.
- R3: A difference above +1023 is sent as +1023, and one below -1024 is sent as -1024. The predictor becomes predictor plus the sent difference, so a large step is reached over several later codes.
- R4: `in_chan` (0..3) selects one of four independent predictors. Only the selected predictor is used and updated by an accepted sample.
- R5: Reset clears all predictors to 0. A `frame_start` pulse also clears them, and a sample accepted in the same cycle as the pulse is coded against 0.
- R6: Code bits fill a word from bit 15 downward in arrival order. A word is offered as soon as 16 bits have gathered, with `out_bits` = 16. Bits that spill over begin the next word.
- R7: `flush` is taken in a cycle with `in_valid` low and `in_ready` high. If 1..15 bits are pending, it emits them left-aligned and zero-padded, with `out_bits` equal to their count. If no bits are pending, no word is emitted.
- R8: While `out_valid` is high and `out_ready` is low, the block holds `out_word` and `out_bits` stable and drives `in_ready` low. No sample or bit is lost.
- R9: While `rst_n` is low, `out_valid` and `in_ready` are 0. Two cycles after reset release, `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_start | input | 1 | Clears all channel predictors |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Sample or flush can be taken |
| in_sample | input | 12 | Raw pixel value |
| in_chan | input | 2 | Channel index of the sample |
| flush | input | 1 | Drain the partial word (taken when in_valid is low) |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the word |
| out_word | output | 16 | Packed code bits, MSB first |
| out_bits | output | 5 | Count of meaningful bits in out_word (1..16) |

## Verification
On every cycle, the assertions check that a stalled word stays stable and blocks input, that `out_bits` stays in 1..16, that the pending bit count stays below one word, and that an accepted flush empties the accumulator. The choice between code lengths, the clamp values, the spread of a large step over later samples, channel separation and the frame-start clear all depend on data. These are shown only by the bench, which compares the emitted stream word by word against its own bit-level model and against hand-decoded words.

// File: rtl/dpe_pkg.sv
package dpe_pkg;
  localparam int DPE_SAMPLE_W = 12;
  localparam int DPE_SHORT_W  = 5;
  localparam int DPE_LONG_W   = 11;
  localparam int DPE_WORD_W   = 16;
  localparam int DPE_CHANNELS = 4;

  typedef enum logic {
    CODE_SHORT = 1'b0,
    CODE_LONG  = 1'b1
  } code_kind_e;
endpackage

// File: rtl/dpe_chan_pred.sv
module dpe_chan_pred #(
  parameter int SAMPLE_W = 12,
  parameter int CHANNELS = 4,
  localparam int CH_W = $clog2(CHANNELS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                upd_en,
  input  logic [CH_W-1:0]     sel_chan,
  input  logic [SAMPLE_W-1:0] upd_value,
  output logic [SAMPLE_W-1:0] rd_value
);
  logic [SAMPLE_W-1:0] pred_q [CHANNELS];
  logic [SAMPLE_W-1:0] pred_d [CHANNELS];

  // a clear in the same cycle as a sample makes the sample see zero
  assign rd_value = clear ? '0 : pred_q[sel_chan];

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    always_comb begin
      pred_d[c] = pred_q[c];
      if (clear) pred_d[c] = '0;
      if (upd_en && (sel_chan == CH_W'(c))) pred_d[c] = upd_value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pred_q[c] <= '0;
      else        pred_q[c] <= pred_d[c];
    end
  end
endmodule

// File: rtl/dpe_code_sel.sv
module dpe_code_sel
  import dpe_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int SHORT_W  = 5,
  parameter int LONG_W   = 11,
  localparam int CODE_W  = LONG_W + 1,
  localparam int LEN_W   = $clog2(CODE_W + 1)
) (
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [SAMPLE_W-1:0] pred,
  output logic [CODE_W-1:0]   code_bits,
  output logic [LEN_W-1:0]    code_len,
  output logic [SAMPLE_W-1:0] recon
);
  localparam int DIFF_W  = SAMPLE_W + 1;
  localparam int S_HI    = (1 << (SHORT_W - 1)) - 1;
  localparam int S_LO    = -(1 << (SHORT_W - 1));
  localparam int L_HI    = (1 << (LONG_W - 1)) - 1;
  localparam int L_LO    = -(1 << (LONG_W - 1));
  localparam logic signed [DIFF_W-1:0] SHI = DIFF_W'(S_HI);
  localparam logic signed [DIFF_W-1:0] SLO = DIFF_W'(S_LO);
  localparam logic signed [DIFF_W-1:0] LHI = DIFF_W'(L_HI);
  localparam logic signed [DIFF_W-1:0] LLO = DIFF_W'(L_LO);

  logic signed [DIFF_W-1:0] diff;
  logic signed [DIFF_W-1:0] sent;
  code_kind_e               kind;

  always_comb begin
    diff = $signed({1'b0, sample}) - $signed({1'b0, pred});
    if (diff > LHI)      sent = LHI;
    else if (diff < LLO) sent = LLO;
    else                 sent = diff;
    kind = ((diff <= SHI) && (diff >= SLO)) ? CODE_SHORT : CODE_LONG;
  end

  always_comb begin
    if (kind == CODE_SHORT) begin
      code_bits = {1'b0, sent[SHORT_W-1:0], {(LONG_W - SHORT_W){1'b0}}};
      code_len  = LEN_W'(SHORT_W + 1);
    end else begin
      code_bits = {1'b1, sent[LONG_W-1:0]};
      code_len  = LEN_W'(CODE_W);
    end
  end

  assign recon = pred + sent[SAMPLE_W-1:0];
endmodule

// File: rtl/dpe_packer.sv
module dpe_packer #(
  parameter int WORD_W  = 16,
  parameter int CODE_W  = 12,
  localparam int LEN_W  = $clog2(CODE_W + 1),
  localparam int BUF_W  = 2 * WORD_W,
  localparam int FILL_W = $clog2(BUF_W),
  localparam int BITS_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_go,
  input  logic [CODE_W-1:0] code_bits,
  input  logic [LEN_W-1:0]  code_len,
  input  logic              flush_go,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic [BITS_W-1:0] out_bits,
  output logic [FILL_W-1:0] fill
);
  logic [WORD_W-1:0] acc_q, acc_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic              vld_q, vld_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [BITS_W-1:0] bits_q, bits_d;
  logic [BUF_W-1:0]  placed, wide;
  logic [FILL_W-1:0] total;
  logic              word_en;

  always_comb begin
    placed = {code_bits, {(BUF_W - CODE_W){1'b0}}} >> fill_q;
    wide   = {acc_q, {WORD_W{1'b0}}} | placed;
    total  = fill_q + FILL_W'(code_len);
  end

  always_comb begin
    acc_d   = acc_q;
    fill_d  = fill_q;
    vld_d   = vld_q && !out_ready;
    word_en = 1'b0;
    word_d  = word_q;
    bits_d  = bits_q;
    if (code_go) begin
      if (total >= FILL_W'(WORD_W)) begin
        word_en = 1'b1;
        word_d  = wide[BUF_W-1 -: WORD_W];
        bits_d  = BITS_W'(WORD_W);
        acc_d   = wide[WORD_W-1:0];
        fill_d  = total - FILL_W'(WORD_W);
      end else begin
        acc_d  = wide[BUF_W-1 -: WORD_W];
        fill_d = total;
      end
    end else if (flush_go && (fill_q != '0)) begin
      word_en = 1'b1;
      word_d  = acc_q;
      bits_d  = BITS_W'(fill_q);
      acc_d   = '0;
      fill_d  = '0;
    end
    if (word_en) vld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      fill_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      fill_q <= fill_d;
      vld_q  <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      bits_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
      bits_q <= bits_d;
    end
  end

  assign out_valid = vld_q;
  assign out_word  = word_q;
  assign out_bits  = bits_q;
  assign fill      = fill_q;
endmodule

// File: rtl/delta_pack_enc.sv
module delta_pack_enc
  import dpe_pkg::*;
#(
  parameter int SAMPLE_W = DPE_SAMPLE_W,
  parameter int SHORT_W  = DPE_SHORT_W,
  parameter int LONG_W   = DPE_LONG_W,
  parameter int WORD_W   = DPE_WORD_W,
  parameter int CHANNELS = DPE_CHANNELS,
  localparam int CH_W    = $clog2(CHANNELS),
  localparam int CODE_W  = LONG_W + 1,
  localparam int LEN_W   = $clog2(CODE_W + 1),
  localparam int FILL_W  = $clog2(2 * WORD_W),
  localparam int BITS_W  = $clog2(WORD_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [CH_W-1:0]     in_chan,
  input  logic                flush,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [WORD_W-1:0]   out_word,
  output logic [BITS_W-1:0]   out_bits
);
  logic [1:0]          rst_sync_q;
  logic                rst_n_sync;
  logic                sample_go, flush_go;
  logic [SAMPLE_W-1:0] pred_val, recon_val;
  logic [CODE_W-1:0]   code_bits;
  logic [LEN_W-1:0]    code_len;
  logic [FILL_W-1:0]   fill_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_sync = rst_sync_q[1];

  assign in_ready  = rst_n_sync && (!out_valid || out_ready);
  assign sample_go = in_valid && in_ready;
  assign flush_go  = flush && !in_valid && in_ready;

  dpe_chan_pred #(.SAMPLE_W(SAMPLE_W), .CHANNELS(CHANNELS)) u_pred (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .clear     (frame_start),
    .upd_en    (sample_go),
    .sel_chan  (in_chan),
    .upd_value (recon_val),
    .rd_value  (pred_val)
  );

  dpe_code_sel #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_code (
    .sample    (in_sample),
    .pred      (pred_val),
    .code_bits (code_bits),
    .code_len  (code_len),
    .recon     (recon_val)
  );

  dpe_packer #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .code_go   (sample_go),
    .code_bits (code_bits),
    .code_len  (code_len),
    .flush_go  (flush_go),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_bits  (out_bits),
    .fill      (fill_lvl)
  );
endmodule

// File: rtl/dpe_checker.sv
module dpe_checker #(
  parameter int WORD_W = 16,
  parameter int FILL_W = 5,
  parameter int BITS_W = 5
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              in_valid,
  input logic              in_ready,
  input logic              flush,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word,
  input logic [BITS_W-1:0] out_bits,
  input logic [FILL_W-1:0] fill
);
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_ok)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_bits)));

  a_r8_block_input: assert property (@(posedge clk) disable iff (!rst_ok)
    (out_valid && !out_ready) |-> !in_ready);

  a_r6_bits_range: assert property (@(posedge clk) disable iff (!rst_ok)
    out_valid |-> ((out_bits != '0) && (out_bits <= BITS_W'(WORD_W))));

  a_r6_fill_below_word: assert property (@(posedge clk) disable iff (!rst_ok)
    fill < FILL_W'(WORD_W));

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_ok)
    (flush && !in_valid && in_ready) |=> (fill == '0));
endmodule

bind delta_pack_enc dpe_checker #(.WORD_W(WORD_W), .FILL_W(FILL_W), .BITS_W(BITS_W)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_n_sync),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .flush     (flush),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word  (out_word),
  .out_bits  (out_bits),
  .fill      (fill_lvl)
);

// File: tb/sim_delta_pack_enc.sv
module sim_delta_pack_enc;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 20;
  // {channel[13:12], sample[11:0]}
  localparam logic [13:0] VEC [NVEC] = '{
    {2'd0, 12'd100},  {2'd1, 12'd2000}, {2'd0, 12'd110},  {2'd0, 12'd94},
    {2'd0, 12'd110},  {2'd1, 12'd1985}, {2'd2, 12'd4095}, {2'd2, 12'd0},
    {2'd3, 12'd1023}, {2'd3, 12'd0},    {2'd3, 12'd1024}, {2'd3, 12'd1025},
    {2'd2, 12'd0},    {2'd1, 12'd3000}, {2'd0, 12'd95},   {2'd0, 12'd111},
    {2'd0, 12'd126},  {2'd2, 12'd17},   {2'd1, 12'd2976}, {2'd3, 12'd4000}
  };

  logic        clk, rst_n, frame_start, in_valid, in_ready, flush;
  logic        out_valid, out_ready;
  logic [11:0] in_sample;
  logic [1:0]  in_chan;
  logic [15:0] out_word;
  logic [4:0]  out_bits;

  int checks = 0, errors = 0, cyc = 0, rdy_mode = 0;
  int mpred [4];
  bit mq [$];
  int exp_w [$], exp_b [$], got_w [$], got_b [$];

  delta_pack_enc u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
    .in_ready(in_ready), .in_sample(in_sample), .in_chan(in_chan), .flush(flush),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word), .out_bits(out_bits)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    case (rdy_mode)
      0:       out_ready = 1'b1;
      1:       out_ready = (cyc % 3) != 0;
      default: out_ready = 1'b0;
    endcase
  end

  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && out_ready) begin
      got_w.push_back(int'(out_word));
      got_b.push_back(int'(out_bits));
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // bit-level model built from the requirements
  function automatic void m_push(int v, int n);
    for (int i = n - 1; i >= 0; i--) mq.push_back(bit'((v >> i) & 1));
    while (mq.size() >= 16) begin
      int w = 0;
      for (int k = 0; k < 16; k++) w = (w << 1) | int'(mq.pop_front());
      exp_w.push_back(w);
      exp_b.push_back(16);
    end
  endfunction

  function automatic void m_sample(int ch, int s);
    int d = s - mpred[ch];
    if (d >= -16 && d <= 15) begin
      m_push(0, 1); m_push(d & 31, 5);
    end else begin
      if (d > 1023) d = 1023;
      if (d < -1024) d = -1024;
      m_push(1, 1); m_push(d & 2047, 11);
    end
    mpred[ch] = mpred[ch] + d;
  endfunction

  function automatic void m_flush();
    if (mq.size() > 0) begin
      int n = mq.size();
      int w = 0;
      for (int k = 0; k < 16; k++) w = (w << 1) | ((mq.size() > 0) ? int'(mq.pop_front()) : 0);
      exp_w.push_back(w);
      exp_b.push_back(n);
    end
  endfunction

  task automatic send(int ch, int s, bit fs);
    @(negedge clk);
    in_valid = 1'b1; in_chan = ch[1:0]; in_sample = s[11:0]; frame_start = fs;
    #2;
    while (!in_ready) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    in_valid = 1'b0; frame_start = 1'b0;
    if (fs) for (int c = 0; c < 4; c++) mpred[c] = 0;
    m_sample(ch, s);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    #2;
    while (!in_ready) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    flush = 1'b0;
    m_flush();
  endtask

  task automatic compare(string tag);
    repeat (10) @(negedge clk);
    chk(got_w.size() == exp_w.size(), {tag, " word count"}, got_w.size(), exp_w.size());
    for (int i = 0; i < exp_w.size() && i < got_w.size(); i++) begin
      chk(got_w[i] == exp_w[i], {tag, " word"}, got_w[i], exp_w[i]);
      chk(got_b[i] == exp_b[i], {tag, " bits"}, got_b[i], exp_b[i]);
    end
    got_w.delete(); got_b.delete(); exp_w.delete(); exp_b.delete();
  endtask

  initial begin
    logic [15:0] held;
    rst_n = 1'b0; frame_start = 1'b0; in_valid = 1'b0; flush = 1'b0;
    in_sample = '0; in_chan = '0; out_ready = 1'b1;
    for (int c = 0; c < 4; c++) mpred[c] = 0;
    repeat (3) @(negedge clk);
    #2;
    chk(out_valid == 1'b0, "R9 out_valid in reset", int'(out_valid), 0);
    chk(in_ready == 1'b0, "R9 in_ready in reset", int'(in_ready), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    chk(in_ready == 1'b1, "R9 in_ready after release", int'(in_ready), 1);

    // R1 R6 R7: one short code then flush -> 0 00101 padded
    send(0, 5, 0);
    do_flush();
    repeat (6) @(negedge clk);
    if (got_w.size() > 0) begin
      chk(got_w[0] == 16'h1400, "R1 short code word", got_w[0], 16'h1400);
      chk(got_b[0] == 6, "R7 flush bit count", got_b[0], 6);
    end else chk(1'b0, "R7 flush word missing", 0, 1);
    compare("R1/R7");

    // R7: flush with nothing pending emits no word
    do_flush();
    repeat (6) @(negedge clk);
    chk(got_w.size() == 0, "R7 empty flush", got_w.size(), 0);

    // R3: step from 0 to 4095 is clamped at +1023 per code
    send(1, 4095, 1);
    for (int i = 0; i < 4; i++) send(1, 4095, 0);
    repeat (6) @(negedge clk);
    if (got_w.size() > 0)
      chk(got_w[0] == 16'hBFFB, "R3 clamp word", got_w[0], 16'hBFFB);
    else chk(1'b0, "R3 clamp word missing", 0, 1);
    do_flush();
    compare("R3");

    // R2 R4 R6 R8: vector table under downstream backpressure
    rdy_mode = 1;
    for (int i = 0; i < NVEC; i++)
      send(int'(VEC[i][13:12]), int'(VEC[i][11:0]), i == 0);
    do_flush();
    rdy_mode = 0;
    compare("R2/R4/R6");

    // R5: frame_start in the same cycle as a sample codes against zero
    send(2, 900, 0);
    send(2, 903, 1);
    send(0, 7, 0);
    do_flush();
    compare("R5");

    // R8: stalled word held, input blocked, nothing lost
    rdy_mode = 2;
    send(3, 500, 1);
    send(3, 0, 0);
    @(negedge clk); #2;
    chk(in_ready == 1'b0, "R8 in_ready during stall", int'(in_ready), 0);
    chk(out_valid == 1'b1, "R8 out_valid during stall", int'(out_valid), 1);
    chk(out_word == 16'h9F4E, "R8 stalled word", int'(out_word), 16'h9F4E);
    held = out_word;
    repeat (3) @(negedge clk);
    #2;
    chk(out_word == held, "R8 word stable", int'(out_word), int'(held));
    rdy_mode = 0;
    send(3, 10, 0);
    do_flush();
    compare("R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule